// File: doc/BRIEF.md
# Configurable Multiply-Accumulate Unit

This block multiplies two 16-bit operands and either presents the product alone or adds it to, or subtracts it from, a 48-bit running accumulator. Each load also selects a 3-bit mode. The mode sets, independently, whether operand A and operand B are read as two's-complement or unsigned, and whether the product overwrites, adds to or subtracts from the accumulator. The multiplier is plain inferred RTL. Both operands are widened to 18 bits before the multiply, and the widened product is sign-extended to the accumulator width.

The input side is a valid/ready stream that never applies back-pressure. `in_ready` is always high, so every cycle with `in_valid` high is a load. On a load, the operands, the mode and the current accumulator value are captured together on one clock edge. The result is combinational from those registers, so it is visible the cycle after the load. `res_valid` marks that cycle. The output side has no ready signal: results stay on the read ports until the next load. The read ports give the low word, the high word and a Q15 fractional word of the accumulator.

Top module: `mac_unit`

## Requirements
- R1: `in_ready` is always 1. Every cycle with `in_valid` high is a load. `res_valid` is 1 in the cycle after each load and 0 in the cycle after a cycle with no load. Back-to-back loads each produce their own result.
- R2: In a cycle that follows no load (and no reset), `res_lo`, `res_hi` and `res_frac` keep their previous values.
- R3: A synchronous reset (`rst` high at a clock edge) clears the accumulator and the captured operands and mode. In the following cycle all three result words and `res_valid` are 0.
- R4: Mode encoding: bit 2 set makes operand A signed. Operand B is signed in modes 1, 4, 6 and 7. Mode 0 multiplies unsigned by unsigned. Mode 4 multiplies signed by signed.
- R5: Mode 1 multiplies an unsigned A by a signed B. Mode 5 multiplies a signed A by an unsigned B.
- R6: Modes 2 (unsigned) and 6 (signed) add the product to the accumulator (mode bit 1 set, low bits not 11).
- R7: Modes 3 (unsigned) and 7 (signed) subtract the product from the accumulator (low two mode bits 11).
- R8: Modes 0, 1, 4 and 5 (mode bit 1 clear) replace the accumulator with the product alone. The product is sign-extended from the 36-bit widened product to 48 bits, and all arithmetic wraps modulo 2^48.
- R9: `res_lo` is accumulator bits 15:0. `res_hi` is bits 31:16. `res_frac` is bits 30:15.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Load strobe: capture operands, mode and accumulator |
| in_ready | output | 1 | Always high; the block accepts every load |
| op_a | input | 16 | Operand A |
| op_b | input | 16 | Operand B |
| mode | input | 3 | Operation mode, encoded per R4 to R8 |
| res_valid | output | 1 | High in the cycle after a load |
| res_lo | output | 16 | Accumulator bits 15:0 |
| res_hi | output | 16 | Accumulator bits 31:16 |
| res_frac | output | 16 | Q15 fractional word, accumulator bits 30:15 |

## Verification
The assertions take for granted that `op_a`, `op_b` and `mode` are free of X whenever `in_valid` is high. They also assume that `rst` is asserted before the first load, so that the accumulator feedback starts from a defined value. The bench holds reset for several cycles at the start and changes inputs only on falling edges, so every sampled input is settled. The sweep covers all eight modes against a set of corner operands: zero, one, the largest positive, the most negative and all-ones. It runs both isolated and back-to-back loads, so the accumulating modes see their feedback both held across idle cycles and captured on consecutive edges.

// File: rtl/mac_pkg.sv
package mac_pkg;

  typedef struct packed {
    logic a_signed;
    logic b_signed;
    logic accumulate;
    logic subtract;
  } mac_cfg_t;

  // Mode bit 2 signs A; B is signed in modes 1, 4, 6, 7.
  // Bit 1 accumulates; low bits 11 subtract.
  function automatic mac_cfg_t decode_mode(input logic [2:0] m);
    mac_cfg_t c;
    c.a_signed   = m[2];
    c.b_signed   = m[2] ^ (m[1:0] == 2'b01);
    c.accumulate = m[1];
    c.subtract   = m[1] & m[0];
    return c;
  endfunction

endpackage

// File: rtl/mac_mode_decode.sv
module mac_mode_decode
  import mac_pkg::*;
(
  input  logic [2:0] mode,
  output mac_cfg_t   cfg
);
  always_comb cfg = decode_mode(mode);
endmodule

// File: rtl/mac_operand_ext.sv
module mac_operand_ext #(
  parameter int IN_W  = 16,
  parameter int EXT_W = 2,
  localparam int OUT_W = IN_W + EXT_W
) (
  input  logic [IN_W-1:0]  din,
  input  logic             is_signed,
  output logic [OUT_W-1:0] dout
);
  logic fill;
  assign fill = is_signed & din[IN_W-1];

  genvar g;
  generate
    for (g = 0; g < EXT_W; g++) begin : g_fill
      assign dout[IN_W+g] = fill;
    end
  endgenerate
  assign dout[IN_W-1:0] = din;
endmodule

// File: rtl/mac_input_stage.sv
module mac_input_stage
  import mac_pkg::*;
#(
  parameter int XW    = 18,
  parameter int ACC_W = 48
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [XW-1:0]    a_in,
  input  logic [XW-1:0]    b_in,
  input  mac_cfg_t         cfg_in,
  input  logic [ACC_W-1:0] fb_in,
  output logic [XW-1:0]    a_q,
  output logic [XW-1:0]    b_q,
  output mac_cfg_t         cfg_q,
  output logic [ACC_W-1:0] fb_q
);
  // Operands, mode and accumulator feedback share one capture edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      a_q   <= '0;
      b_q   <= '0;
      cfg_q <= '0;
      fb_q  <= '0;
    end else if (load) begin
      a_q   <= a_in;
      b_q   <= b_in;
      cfg_q <= cfg_in;
      fb_q  <= fb_in;
    end
  end
endmodule

// File: rtl/mac_accum.sv
module mac_accum
  import mac_pkg::*;
#(
  parameter int XW    = 18,
  parameter int ACC_W = 48,
  localparam int PW   = 2 * XW
) (
  input  logic [XW-1:0]    a_x,
  input  logic [XW-1:0]    b_x,
  input  mac_cfg_t         cfg,
  input  logic [ACC_W-1:0] fb,
  output logic [ACC_W-1:0] acc
);
  logic signed [PW-1:0] prod;
  logic [ACC_W-1:0]     prod_w;

  assign prod   = $signed(a_x) * $signed(b_x);
  assign prod_w = {{(ACC_W-PW){prod[PW-1]}}, prod};

  always_comb begin
    if (!cfg.accumulate)   acc = prod_w;
    else if (cfg.subtract) acc = fb - prod_w;
    else                   acc = fb + prod_w;
  end
endmodule

// File: rtl/mac_unit.sv
module mac_unit
  import mac_pkg::*;
#(
  parameter int OP_W  = 16,
  parameter int EXT_W = 2,
  parameter int ACC_W = 48,
  localparam int XW       = OP_W + EXT_W,
  localparam int FRAC_LSB = OP_W - 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [OP_W-1:0] op_a,
  input  logic [OP_W-1:0] op_b,
  input  logic [2:0]      mode,
  output logic            res_valid,
  output logic [OP_W-1:0] res_lo,
  output logic [OP_W-1:0] res_hi,
  output logic [OP_W-1:0] res_frac
);
  mac_cfg_t         cfg_d, cfg_q;
  logic [XW-1:0]    a_x, b_x, a_q, b_q;
  logic [ACC_W-1:0] acc, fb_q;

  assign in_ready = 1'b1;

  mac_mode_decode u_dec (.mode(mode), .cfg(cfg_d));

  mac_operand_ext #(.IN_W(OP_W), .EXT_W(EXT_W)) u_ext_a (
    .din(op_a), .is_signed(cfg_d.a_signed), .dout(a_x));
  mac_operand_ext #(.IN_W(OP_W), .EXT_W(EXT_W)) u_ext_b (
    .din(op_b), .is_signed(cfg_d.b_signed), .dout(b_x));

  mac_input_stage #(.XW(XW), .ACC_W(ACC_W)) u_in (
    .clk(clk), .rst(rst), .load(in_valid),
    .a_in(a_x), .b_in(b_x), .cfg_in(cfg_d), .fb_in(acc),
    .a_q(a_q), .b_q(b_q), .cfg_q(cfg_q), .fb_q(fb_q));

  mac_accum #(.XW(XW), .ACC_W(ACC_W)) u_acc (
    .a_x(a_q), .b_x(b_q), .cfg(cfg_q), .fb(fb_q), .acc(acc));

  always_ff @(posedge clk) begin
    if (rst) res_valid <= 1'b0;
    else     res_valid <= in_valid;
  end

  assign res_lo   = acc[OP_W-1:0];
  assign res_hi   = acc[2*OP_W-1:OP_W];
  assign res_frac = acc[FRAC_LSB+OP_W-1:FRAC_LSB];

  // R1: a load yields a flagged result next cycle; idle yields none
  p_valid_after_load_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> res_valid);
  p_no_valid_when_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !res_valid);

  // R2: no load, no change
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(in_valid) && !$past(rst)) |-> ($stable(res_lo) && $stable(res_hi)));

  // R3: reset clears the visible result
  p_reset_clear_r3: assert property (@(posedge clk)
    $past(rst) |-> (res_lo == '0 && res_hi == '0 && !res_valid));

  // R4: unsigned A times one returns A unchanged with a clear high word
  p_unsigned_identity_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == 3'd0 && op_b == 1) |=>
      (res_lo == $past(op_a) && res_hi == '0));

  // R4: signed product of two non-negative operands is non-negative
  p_signed_pos_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == 3'd4 && !op_a[OP_W-1] && !op_b[OP_W-1]) |=> !res_hi[OP_W-1]);

  // R6: accumulating a zero product leaves the result unchanged
  p_acc_zero_keep_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode[1] && op_a == '0) |=> ($stable(res_lo) && $stable(res_hi)));

  // R7: subtracting 1*1 decrements the visible result
  p_sub_one_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == 3'd3 && op_a == 1 && op_b == 1) |=>
      ({res_hi, res_lo} == $past({res_hi, res_lo}) - 1'b1));

  // R8: non-accumulating mode with a zero operand clears the result
  p_overwrite_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !mode[1] && (op_a == '0 || op_b == '0)) |=>
      (res_lo == '0 && res_hi == '0));
endmodule

// File: tb/mac_unit_bench.sv
module mac_unit_bench;
  logic clk = 1'b0;
  logic rst;
  logic in_valid;
  logic in_ready;
  logic [15:0] op_a, op_b;
  logic [2:0] mode;
  logic res_valid;
  logic [15:0] res_lo, res_hi, res_frac;

  int checks = 0;
  int failures = 0;
  logic [47:0] model = '0;
  bit done = 0;

  always #4 clk = ~clk;

  mac_unit u_mac_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .op_a(op_a), .op_b(op_b), .mode(mode), .res_valid(res_valid),
    .res_lo(res_lo), .res_hi(res_hi), .res_frac(res_frac));

  logic [15:0] corners [8];
  initial begin
    corners[0] = 16'h0000; corners[1] = 16'h0001; corners[2] = 16'h7FFF;
    corners[3] = 16'h8000; corners[4] = 16'hFFFF; corners[5] = 16'h1234;
    corners[6] = 16'hC3A5; corners[7] = 16'h0100;
  end

  function automatic string mode_req(input logic [2:0] m);
    case (m)
      3'd0, 3'd4: return "R4";
      3'd1, 3'd5: return "R5";
      3'd2, 3'd6: return "R6";
      default:    return "R7";
    endcase
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_step(input logic [15:0] a, input logic [15:0] b, input logic [2:0] m);
    longint pa, pb;
    logic [63:0] t;
    pa = m[2] ? longint'($signed(a)) : longint'(a);
    pb = (m[2] ^ (m[1:0] == 2'b01)) ? longint'($signed(b)) : longint'(b);
    t = 64'(pa * pb);
    if (!m[1])      model = t[47:0];
    else if (m[0])  model = model - t[47:0];
    else            model = model + t[47:0];
  endtask

  // Called at a falling edge; leaves in_valid high for back-to-back use.
  task automatic load_step(input logic [15:0] a, input logic [15:0] b, input logic [2:0] m);
    in_valid = 1'b1; op_a = a; op_b = b; mode = m;
    @(negedge clk);
    model_step(a, b, m);
    check("R1", {63'd0, res_valid}, 64'd1);
    check(mode_req(m), {32'd0, res_hi, res_lo}, {32'd0, model[31:0]});
    check(m[1] ? mode_req(m) : "R8", {32'd0, res_hi, res_lo}, {32'd0, model[31:0]});
    check("R9", {48'd0, res_frac}, {48'd0, model[30:15]});
  endtask

  task automatic idle_check();
    logic [15:0] lo0, hi0;
    lo0 = res_lo; hi0 = res_hi;
    in_valid = 1'b0; op_a = 16'hDEAD; op_b = 16'hBEEF; mode = 3'd2;
    @(negedge clk);
    check("R1", {63'd0, res_valid}, 64'd0);
    check("R2", {32'd0, res_hi, res_lo}, {32'd0, hi0, lo0});
  endtask

  task automatic do_reset();
    rst = 1'b1; in_valid = 1'b0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    model = '0;
    check("R3", {16'd0, res_hi, res_lo, res_frac}, 64'd0);
    check("R3", {63'd0, res_valid}, 64'd0);
  endtask

  initial begin
    rst = 1'b1; in_valid = 1'b0; op_a = '0; op_b = '0; mode = '0;
    @(negedge clk); @(negedge clk); @(negedge clk);
    do_reset();
    check("R1", {63'd0, in_ready}, 64'd1);

    // Isolated loads: every mode against every corner pair
    for (int m = 0; m < 8; m++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++) begin
          load_step(corners[i], corners[j], 3'(m));
          idle_check();
        end

    // Back-to-back accumulating bursts
    for (int m = 2; m < 8; m++) begin
      if (m == 4) continue;
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          load_step(corners[i], corners[(i + j) % 8], 3'(m));
      idle_check();
    end

    // Mixed-mode burst walking through all modes
    for (int k = 0; k < 64; k++)
      load_step(corners[k % 8], corners[(k * 3) % 8], 3'(k % 8));
    idle_check();

    // Reset in the middle clears an accumulated value
    load_step(16'h7FFF, 16'h7FFF, 3'd6);
    load_step(16'h7FFF, 16'h7FFF, 3'd6);
    do_reset();
    load_step(16'h0003, 16'h0005, 3'd2);
    idle_check();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule